// File: doc/BRIEF.md
# Dual DAC Serial Load Controller

This block is the digital front end of a two-channel 12-bit voltage-output converter. A host shifts a 16-bit word into it over three wires (serial data, serial clock, active-low select). The word carries a 12-bit code, two target bits and a flag. The flag chooses how a later load is steered: either by two active-low load strobes, one per channel, or by the target bits inside the word. The last shift stage is driven out on a serial output, so several blocks can share one host link in a chain.

Every external input is brought into a faster system clock through a two-flop synchroniser, and edges are found after synchronisation. An asynchronous active-low preset forces both channel registers to zero or to midscale, as chosen by a level input. The two 12-bit register values are the outputs that feed the converter core.

Top module: `dual_dac_loader`

## Requirements
- R1: On each synchronised rising edge of `sclk` while `cs_n` is low, the 16-bit shift register takes `sdi` at its low end, so the first bit sent ends in bit 15. The word layout is: bit 15 is the steering flag (0 = strobe steering, 1 = address steering), bit 14 targets channel B, bit 13 targets channel A, bit 12 is spare, and bits 11..0 are the code, with bit 11 sent first.
- R2: While `cs_n` is high, rising edges of `sclk` leave the shift register unchanged.
- R3: `sdo` is always driven with bit 15 of the shift register, so it shows the `sdi` bit from 16 shift edges earlier.
- R4: With the flag at 0, a falling edge of `ld_a_n` copies code bits 11..0 into `dac_a`, and a falling edge of `ld_b_n` copies them into `dac_b`. Both falling together load both registers.
- R5: With the flag at 1, a falling edge of either strobe starts one load. The load goes to `dac_a` if bit 13 is set and to `dac_b` if bit 14 is set. With neither bit set, nothing is loaded.
- R6: `cs_n` has no effect on loads.
- R7: While `preset_n` is low, both registers are forced at once to 0x800 if `mid_sel` is 1, or to 0x000 if it is 0. This overrides any load, and the shift register and synchronisers are cleared as well. After release, the registers hold the preset value until the next strobe falling edge.
- R8: Bit 12 of the word has no effect on any load.
- R9: A strobe falling edge changes the target register on the third rising `clk` edge after the strobe input changes, and one strobe edge gives exactly one update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `sclk` |
| preset_n | input | 1 | Asynchronous active-low preset |
| mid_sel | input | 1 | Preset value select: 1 = midscale, 0 = zero |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low shift enable |
| ld_a_n | input | 1 | Active-low load strobe A |
| ld_b_n | input | 1 | Active-low load strobe B |
| sdo | output | 1 | Serial data out for chaining |
| dac_a | output | 12 | Channel A register value |
| dac_b | output | 12 | Channel B register value |

## Verification
Each input change passes through two synchroniser flops before any edge is detected. A shift or a load therefore lands on the third rising `clk` edge after the input changes. The bench drives its inputs on falling clock edges and leaves at least three clock periods after every `sclk` or strobe transition before it samples. For one load it samples after the second edge and again after the third edge, to check that the update lands on the third edge exactly. Chain output checks are made between shifts, after each shift has settled.

// File: rtl/dual_dac_loader.sv
module dual_dac_loader #(
  parameter int DATA_W      = 12,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              preset_n,
  input  logic              mid_sel,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic              ld_a_n,
  input  logic              ld_b_n,
  output logic              sdo,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b
);
  localparam int MODE_BIT = WORD_W - 1;
  localparam int SEL_B    = WORD_W - 2;
  localparam int SEL_A    = WORD_W - 3;
  localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);
  localparam logic [4:0] SYNC_IDLE = 5'b00111;

  logic [4:0] sync_q [SYNC_STAGES];
  logic [4:0] sync_s;
  logic       sclk_d, lda_d, ldb_d;
  logic [WORD_W-1:0] sr;
  logic       shift_en, fall_a, fall_b, load_a, load_b;
  logic [DATA_W-1:0] preset_val;

  always_ff @(posedge clk or negedge preset_n) begin
    if (!preset_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_IDLE;
    end else begin
      sync_q[0] <= {sclk, sdi, cs_n, ld_a_n, ld_b_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign sync_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge preset_n) begin
    if (!preset_n) begin
      sclk_d <= 1'b0;
      lda_d  <= 1'b1;
      ldb_d  <= 1'b1;
    end else begin
      sclk_d <= sync_s[4];
      lda_d  <= sync_s[1];
      ldb_d  <= sync_s[0];
    end
  end

  assign shift_en = sync_s[4] & ~sclk_d & ~sync_s[2];
  assign fall_a   = lda_d & ~sync_s[1];
  assign fall_b   = ldb_d & ~sync_s[0];

  always_ff @(posedge clk or negedge preset_n) begin
    if (!preset_n)     sr <= '0;
    else if (shift_en) sr <= {sr[WORD_W-2:0], sync_s[3]};
  end

  assign sdo = sr[WORD_W-1];

  assign load_a = sr[MODE_BIT] ? ((fall_a | fall_b) & sr[SEL_A]) : fall_a;
  assign load_b = sr[MODE_BIT] ? ((fall_a | fall_b) & sr[SEL_B]) : fall_b;

  assign preset_val = mid_sel ? MIDSCALE : '0;

  always_ff @(posedge clk or negedge preset_n) begin
    if (!preset_n)   dac_a <= preset_val;
    else if (load_a) dac_a <= sr[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge preset_n) begin
    if (!preset_n)   dac_b <= preset_val;
    else if (load_b) dac_b <= sr[DATA_W-1:0];
  end
endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk #(
  parameter int DATA_W = 12,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              preset_n,
  input logic              mid_sel,
  input logic              cs_n,
  input logic              sdo,
  input logic              shift_en,
  input logic              load_a,
  input logic              load_b,
  input logic [WORD_W-1:0] sr,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b
);
  localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

  assert_preset_value_R7: assert property (@(posedge clk)
    $rose(preset_n) |-> (dac_a == (mid_sel ? MIDSCALE : '0)) && (dac_b == (mid_sel ? MIDSCALE : '0)));

  assert_dac_a_only_on_load_R4: assert property (@(posedge clk) disable iff (!preset_n)
    (dac_a != $past(dac_a)) |-> $past(load_a));

  assert_dac_b_only_on_load_R5: assert property (@(posedge clk) disable iff (!preset_n)
    (dac_b != $past(dac_b)) |-> $past(load_b));

  assert_hold_when_deselected_R2: assert property (@(posedge clk) disable iff (!preset_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> $stable(sdo));

  assert_sdo_moves_on_shift_R3: assert property (@(posedge clk) disable iff (!preset_n)
    (sdo != $past(sdo)) |-> $past(shift_en));

  assert_no_target_no_load_R5: assert property (@(posedge clk) disable iff (!preset_n)
    ($past(sr[WORD_W-1]) && $past(sr[WORD_W-2:WORD_W-3]) == 2'b00) |-> ($stable(dac_a) && $stable(dac_b)));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .preset_n(preset_n), .mid_sel(mid_sel), .cs_n(cs_n), .sdo(sdo),
  .shift_en(shift_en), .load_a(load_a), .load_b(load_b), .sr(sr),
  .dac_a(dac_a), .dac_b(dac_b)
);

// File: tb/test_dual_dac_loader.sv
module test_dual_dac_loader;
  logic clk = 1'b0;
  logic preset_n = 1'b0, mid_sel = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, ld_a_n = 1'b1, ld_b_n = 1'b1;
  logic sdo;
  logic [11:0] dac_a, dac_b;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [11:0] ea, eb;

  always #4 clk = ~clk;

  dual_dac_loader i_dual_dac_loader (
    .clk(clk), .preset_n(preset_n), .mid_sel(mid_sel), .sclk(sclk), .sdi(sdi),
    .cs_n(cs_n), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .sdo(sdo),
    .dac_a(dac_a), .dac_b(dac_b)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic clock_bit(logic b);
    sdi = b; tick(3);
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(3);
  endtask

  task automatic send_word(logic [15:0] w);
    cs_n = 1'b0; tick(2);
    for (int i = 15; i >= 0; i--) clock_bit(w[i]);
    cs_n = 1'b1; tick(3);
  endtask

  task automatic strobe(logic a, logic b, logic cs_during);
    cs_n = cs_during;
    ld_a_n = ~a; ld_b_n = ~b; tick(4);
    ld_a_n = 1'b1; ld_b_n = 1'b1; tick(4);
    cs_n = 1'b1; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R7 zero preset a", {4'h0, dac_a}, 16'h0000);
    chk("R7 zero preset b", {4'h0, dac_b}, 16'h0000);
    preset_n = 1'b1; tick(3);
    mid_sel = 1'b1; preset_n = 1'b0; tick(3);
    chk("R7 midscale a", {4'h0, dac_a}, 16'h0800);
    chk("R7 midscale b", {4'h0, dac_b}, 16'h0800);
    preset_n = 1'b1; tick(10);
    chk("R7 hold after release", {4'h0, dac_a}, 16'h0800);
    ea = 12'h800; eb = 12'h800;

    // R1 R4 R9: exact latency of a load
    send_word(16'h0ABC);
    ld_a_n = 1'b0;
    tick(2);
    chk("R9 not before third edge", {4'h0, dac_a}, 16'h0800);
    tick(1);
    chk("R9 on third edge", {4'h0, dac_a}, 16'h0ABC);
    tick(5);
    chk("R9 single update while held", {4'h0, dac_a}, 16'h0ABC);
    ld_a_n = 1'b1; tick(4);
    chk("R4 b untouched", {4'h0, dac_b}, 16'h0800);
    ea = 12'hABC;

    // R2: clocking with cs_n high changes nothing
    send_word(16'h0123);
    cs_n = 1'b1;
    for (int i = 0; i < 16; i++) clock_bit(i[0]);
    chk("R2 sdo held", {15'h0, sdo}, 16'h0000);
    strobe(1'b1, 1'b1, 1'b1);
    ea = 12'h123; eb = 12'h123;
    chk("R2 word kept a", {4'h0, dac_a}, {4'h0, ea});
    chk("R2 word kept b", {4'h0, dac_b}, {4'h0, eb});

    // R3: chain output shows bits from 16 shifts earlier
    send_word(16'hB5C3);
    cs_n = 1'b0; tick(2);
    for (int j = 0; j < 16; j++) begin
      chk("R3 chained bit", {15'h0, sdo}, {15'h0, 1'(16'hB5C3 >> (15 - j))});
      clock_bit(1'((16'h4E29) >> (15 - j)));
    end
    cs_n = 1'b1; tick(3);
    chk("R3 new msb out", {15'h0, sdo}, 16'h0000);

    // R4 R5 R6 R8 sweep over flag, targets, strobes, spare bit and select level
    for (int mode = 0; mode < 2; mode++)
      for (int addr = 0; addr < 4; addr++)
        for (int st = 1; st < 4; st++) begin
          int k = mode * 12 + addr * 3 + st;
          logic [11:0] data = 12'((k * 613 + 77) & 12'hFFF);
          logic [15:0] w = {mode[0], addr[1], addr[0], k[0], data};
          send_word(w);
          strobe(st[0], st[1], k[1] ? 1'b0 : 1'b1);
          if (mode == 0) begin
            if (st[0]) ea = data;
            if (st[1]) eb = data;
          end else begin
            if (addr[0]) ea = data;
            if (addr[1]) eb = data;
          end
          chk(mode ? "R5 R6 R8 address load a" : "R4 R6 R8 strobe load a", {4'h0, dac_a}, {4'h0, ea});
          chk(mode ? "R5 R6 R8 address load b" : "R4 R6 R8 strobe load b", {4'h0, dac_b}, {4'h0, eb});
        end

    // R7: preset overrides a load in the same window
    send_word(16'h0777);
    mid_sel = 1'b0;
    preset_n = 1'b0; ld_a_n = 1'b0; ld_b_n = 1'b0; tick(5);
    ld_a_n = 1'b1; ld_b_n = 1'b1; tick(2);
    preset_n = 1'b1; tick(8);
    chk("R7 priority a", {4'h0, dac_a}, 16'h0000);
    chk("R7 priority b", {4'h0, dac_b}, 16'h0000);
    chk("R7 shift cleared", {15'h0, sdo}, 16'h0000);
    finish_run();
  end
endmodule